// File: doc/BRIEF.md
# Wake and Suspend Event Controller

This block watches an asynchronous activation-tone (wake) input and turns each rising edge into a power-management action. The action depends on the host-interface select pin. With the host-bus interface selected, the edge latches a sticky wake status. That status drives an active-low, open-drain power-management event line when the event is enabled, and a level-sensitive, open-drain interrupt line when the interrupt is enabled. With USB selected, the edge ends a software-requested suspend, and the status is left alone.

Software uses a small write/read port. One control register holds the two enables and the suspend request. One status register holds the sticky wake bit, which is cleared by writing 1. The suspend indication leaves the block as a true output and a negated output, and the two are always complementary.

Both open-drain outputs appear as "pull" signals. A 1 means the pad drives the line low, and a 0 means the line floats. Both pull signals are plain combinational functions of held state, with no clock on the path to the pad.

Top module: `wkev_ctrl`

## Requirements
- R1: Only a rising edge on `wake_in` is an event. It takes effect on the third rising clock edge after `wake_in` goes high, and nothing has changed after the second. A falling edge or a steady level changes nothing.
- R2: One rising edge produces exactly one event. After the status is cleared while `wake_in` is still held high, the status stays clear.
- R3: With `sel_usb`=0, a wake event sets the status bit (address 1, bit 0) whatever the enables hold.
- R4: `evt_pull` is 1 exactly while the status is set and the event enable (address 0, bit 0) is 1. Clearing the enable or the status releases it.
- R5: `irq_pull` is 1 exactly while the status is set and the interrupt enable (address 0, bit 1) is 1.
- R6: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. A wake event in the same cycle as the clear leaves the status set.
- R7: With `sel_usb`=1, a wake event leaves the status untouched and clears the suspend state if it is set.
- R8: Writing address 0 loads the suspend state from bit 2. Reading address 0 returns the two enables and the suspend state at bits 0, 1 and 2.
- R9: A wake event while not suspended leaves `susp` and `susp_n` unchanged, in either mode.
- R10: `susp_n` is always the complement of `susp`. After reset, `susp`=0, `susp_n`=1, both pull outputs are 0, and every register reads 0.
- R11: A control write in the same cycle as a USB-mode wake event wins: the suspend state takes the written bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wake_in | input | 1 | Asynchronous activation-tone / wake input |
| sel_usb | input | 1 | Interface select: 0 host bus, 1 USB |
| acc_we | input | 1 | Register write strobe |
| acc_addr | input | ADDR_W | Register address (0 control, 1 status) |
| acc_wdata | input | DATA_W | Register write data |
| acc_rdata | output | DATA_W | Read data for `acc_addr` (combinational) |
| evt_pull | output | 1 | 1 = drive power-management event line low |
| irq_pull | output | 1 | 1 = drive interrupt line low |
| susp | output | 1 | Suspend indication |
| susp_n | output | 1 | Negated suspend indication |

## Verification
The hardest situation to reach from the ports is a register write that lands in exactly the one cycle when the synchronised edge pulse is live. This covers both the status clear against a new event and the suspend write against a USB wake. The bench raises `wake_in` at a falling clock edge and counts two rising edges. It then places the write strobe so that the third rising edge captures both the write and the edge pulse. The same fixed latency also lets the bench confirm that nothing has moved after the second edge.

// File: rtl/wkev_pkg.sv
package wkev_pkg;
  localparam int unsigned ADR_CTRL   = 0;
  localparam int unsigned ADR_STAT   = 1;
  localparam int unsigned B_EVT_EN   = 0;
  localparam int unsigned B_IRQ_EN   = 1;
  localparam int unsigned B_SUSP     = 2;
  localparam int unsigned B_WAKE     = 0;
  localparam int unsigned MIN_DATA_W = 3;

  typedef struct packed {
    logic irq_en;
    logic evt_en;
  } wkev_en_t;
endpackage

// File: rtl/wkev_edge.sv
module wkev_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  localparam int unsigned LAST = STAGES;

  logic [LAST:0] pipe_q;
  logic [LAST:0] pipe_d;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("wkev_edge needs at least two stages");
    end
  endgenerate

  always_comb begin
    pipe_d = {pipe_q[LAST-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise_o = pipe_q[LAST-1] & ~pipe_q[LAST];
endmodule

// File: rtl/wkev_regs.sv
module wkev_regs
  import wkev_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_mode,
  input  logic              wake_rise,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output wkev_en_t          en,
  output logic              stat,
  output logic              susp,
  output logic              susp_n
);
  logic     hit_ctrl, hit_stat;
  wkev_en_t en_q, en_d;
  logic     stat_q, stat_d;
  logic     susp_q, susp_d;
  logic     suspn_q, suspn_d;
  logic     en_ce, stat_ce, susp_ce;

  assign hit_ctrl = we && (addr == ADDR_W'(ADR_CTRL));
  assign hit_stat = we && (addr == ADDR_W'(ADR_STAT));

  always_comb begin
    en_d        = en_q;
    en_ce       = hit_ctrl;
    en_d.evt_en = wdata[B_EVT_EN];
    en_d.irq_en = wdata[B_IRQ_EN];
  end

  always_comb begin
    stat_d  = stat_q;
    stat_ce = 1'b0;
    if (hit_stat && wdata[B_WAKE]) begin
      stat_d  = 1'b0;
      stat_ce = 1'b1;
    end
    if (!usb_mode && wake_rise) begin
      stat_d  = 1'b1;
      stat_ce = 1'b1;
    end
  end

  always_comb begin
    susp_d  = susp_q;
    susp_ce = 1'b0;
    if (usb_mode && wake_rise && susp_q) begin
      susp_d  = 1'b0;
      susp_ce = 1'b1;
    end
    if (hit_ctrl) begin
      susp_d  = wdata[B_SUSP];
      susp_ce = 1'b1;
    end
    suspn_d = ~susp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      stat_q  <= 1'b0;
      susp_q  <= 1'b0;
      suspn_q <= 1'b1;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (stat_ce) stat_q <= stat_d;
      if (susp_ce) begin
        susp_q  <= susp_d;
        suspn_q <= suspn_d;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADR_CTRL)) begin
      rdata[B_EVT_EN] = en_q.evt_en;
      rdata[B_IRQ_EN] = en_q.irq_en;
      rdata[B_SUSP]   = susp_q;
    end else if (addr == ADDR_W'(ADR_STAT)) begin
      rdata[B_WAKE] = stat_q;
    end
  end

  assign en     = en_q;
  assign stat   = stat_q;
  assign susp   = susp_q;
  assign susp_n = suspn_q;
endmodule

// File: rtl/wkev_ctrl.sv
module wkev_ctrl
  import wkev_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wake_in,
  input  logic              sel_usb,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              evt_pull,
  output logic              irq_pull,
  output logic              susp,
  output logic              susp_n
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_q_n;
  logic                  wake_rise;
  wkev_en_t              en;
  logic                  stat;

  generate
    if (DATA_W < MIN_DATA_W) begin : g_bad_w
      initial $error("wkev_ctrl data width too small");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[RST_STAGES-1];

  wkev_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .async_in (wake_in),
    .rise_o   (wake_rise)
  );

  wkev_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .usb_mode  (sel_usb),
    .wake_rise (wake_rise),
    .we        (acc_we),
    .addr      (acc_addr),
    .wdata     (acc_wdata),
    .rdata     (acc_rdata),
    .en        (en),
    .stat      (stat),
    .susp      (susp),
    .susp_n    (susp_n)
  );

  assign evt_pull = stat & en.evt_en;
  assign irq_pull = stat & en.irq_en;
endmodule

// File: rtl/wkev_chk.sv
module wkev_chk #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_usb,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              wake_rise,
  input logic              stat,
  input logic              susp,
  input logic              susp_n,
  input logic              evt_pull,
  input logic              irq_pull
);
  logic ctrl_wr;
  assign ctrl_wr = acc_we && (acc_addr == ADDR_W'(0));

  AST_SUSP_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    susp_n == !susp); // R10
  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rise |=> !wake_rise); // R2
  AST_HOST_SETS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_rise && !sel_usb) |=> stat); // R3
  AST_USB_KEEPS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_usb && !stat) |=> !stat); // R7
  AST_USB_WAKE_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_usb && wake_rise && susp && !ctrl_wr) |=> !susp); // R7
  AST_IDLE_WAKE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_rise && !susp && !ctrl_wr) |=> !susp); // R9
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && acc_addr == ADDR_W'(1) && acc_wdata[0] && !wake_rise) |=> !stat); // R6
  AST_EVT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !stat |-> !evt_pull); // R4
  AST_IRQ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !stat |-> !irq_pull); // R5
endmodule

bind wkev_ctrl wkev_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .sel_usb   (sel_usb),
  .acc_we    (acc_we),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata),
  .wake_rise (wake_rise),
  .stat      (stat),
  .susp      (susp),
  .susp_n    (susp_n),
  .evt_pull  (evt_pull),
  .irq_pull  (irq_pull)
);

// File: tb/wkev_ctrl_bench.sv
module wkev_ctrl_bench;
  localparam int AW = 2;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wake_in = 1'b0;
  logic          sel_usb = 1'b0;
  logic          acc_we = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [DW-1:0] acc_rdata;
  logic          evt_pull, irq_pull, susp, susp_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  wkev_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_wkev_ctrl (
    .clk(clk), .rst_n(rst_n), .wake_in(wake_in), .sel_usb(sel_usb),
    .acc_we(acc_we), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .evt_pull(evt_pull), .irq_pull(irq_pull),
    .susp(susp), .susp_n(susp_n)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<100000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    acc_addr = AW'(a);
    #1;
    v = acc_rdata;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    acc_we = 1'b1; acc_addr = AW'(a); acc_wdata = DW'(d);
    @(negedge clk);
    acc_we = 1'b0;
  endtask

  // raise wake at a falling edge; report the status seen after two rising edges
  task automatic rise_wake(output logic early);
    logic [DW-1:0] v;
    @(negedge clk);
    wake_in = 1'b1;
    repeat (2) @(negedge clk);
    rd(1, v);
    early = v[0];
    @(negedge clk);
  endtask

  task automatic drop_wake();
    @(negedge clk);
    wake_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] v;
    logic early;
    repeat (3) @(negedge clk);
    chk(evt_pull, 0, "R10 evt floats in reset");
    chk(irq_pull, 0, "R10 irq floats in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(susp, 0, "R10 susp after reset");
    chk(susp_n, 1, "R10 susp_n after reset");
    rd(0, v); chk(v, 0, "R10 ctrl after reset");
    rd(1, v); chk(v, 0, "R10 stat after reset");

    // sweep: mode x enables x suspend
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        sel_usb = m[0];
        wr(1, 1);
        wr(0, c);
        rd(0, v); chk(v, c, "R8 ctrl readback");
        chk(susp, (c >> 2) & 1, "R8 suspend entry");
        chk(susp_n, ((c >> 2) & 1) ^ 1, "R10 complement");
        rise_wake(early);
        chk(early, 0, "R1 no effect after two edges");
        rd(1, v);
        chk(v[0], (m == 0) ? 1 : 0, (m == 0) ? "R3 host sets status" : "R7 usb leaves status");
        chk(evt_pull, (m == 0) ? (c & 1) : 0, "R4 event pull");
        chk(irq_pull, (m == 0) ? ((c >> 1) & 1) : 0, "R5 interrupt pull");
        chk(susp, (m == 1) ? 0 : ((c >> 2) & 1), (m == 1) ? "R7 usb wake resumes" : "R9 host wake keeps suspend");
        chk(susp_n, (m == 1) ? 1 : (((c >> 2) & 1) ^ 1), "R10 complement after wake");
        if (m == 0) begin
          wr(1, 0);
          rd(1, v); chk(v[0], 1, "R6 write 0 keeps status");
          wr(0, c & 6);
          chk(evt_pull, 0, "R4 disable releases event");
          chk(irq_pull, (c >> 1) & 1, "R5 irq kept by its enable");
          wr(1, 1);
          rd(1, v); chk(v[0], 0, "R6 write 1 clears");
          repeat (3) @(negedge clk);
          rd(1, v); chk(v[0], 0, "R2 held high gives one event");
          chk(irq_pull, 0, "R5 irq releases after clear");
        end
        drop_wake();
        rd(1, v); chk(v[0], 0, "R1 falling edge ignored");
        chk(susp, (m == 1) ? 0 : ((c >> 2) & 1), "R9 fall keeps suspend");
      end
    end

    // R9: usb, not suspended, wake leaves suspend low
    sel_usb = 1'b1;
    wr(0, 0);
    rise_wake(early);
    chk(susp, 0, "R9 idle wake keeps susp low");
    chk(susp_n, 1, "R9 idle wake keeps susp_n high");
    drop_wake();

    // R11: suspend write coincides with usb wake pulse
    @(negedge clk); wake_in = 1'b1;
    repeat (2) @(negedge clk);
    acc_we = 1'b1; acc_addr = AW'(0); acc_wdata = DW'(4);
    @(negedge clk); acc_we = 1'b0;
    chk(susp, 1, "R11 write wins over wake");
    chk(susp_n, 0, "R11 complement");
    drop_wake();

    // R6: clear coincides with host wake pulse, set wins
    sel_usb = 1'b0;
    wr(0, 3);
    rise_wake(early);
    drop_wake();
    rd(1, v); chk(v[0], 1, "R6 status set before race");
    @(negedge clk); wake_in = 1'b1;
    repeat (2) @(negedge clk);
    acc_we = 1'b1; acc_addr = AW'(1); acc_wdata = DW'(1);
    @(negedge clk); acc_we = 1'b0;
    rd(1, v); chk(v[0], 1, "R6 set wins over clear");
    chk(evt_pull, 1, "R4 event held after race");
    drop_wake();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule